// File: doc/BRIEF.md
# Single-Cycle Processor Control Unit

This block sequences and steers a single-cycle 16-bit processor. It holds the program counter and presents it as the instruction-memory address. Every cycle it turns the current 16-bit instruction into a datapath control word. The control word carries register-file write enable, destination and source selects, an immediate-operand select, a memory-or-ALU write-back select, an ALU function code and a data-memory write enable. The register file, ALU and both memories live outside the block.

Flow control is internal. A branch unit takes the ALU status flags (overflow, carry, negative, zero) for the instruction that is executing now. It then picks the next program counter from three choices: the next sequential address, the current address plus a signed 6-bit offset for a jump, or that same target for a branch whose condition holds.

The opcode group is instruction bits [15:13]:
- 000 register ALU
- 001 register shift
- 010 store
- 011 load
- 100 immediate ALU
- 101 immediate shift
- 110 branch
- 111 jump

The branch offset is bits [8:6] followed by bits [2:0], read as two's complement. The branch condition is bits [11:9].

Top module: `cpu_ctl`

## Requirements
- R1: While `rst_ni` is low, the program counter is 0. `imem_addr_o` always equals the program counter.
- R2: `rf_dst_o` = instr[8:6], `rf_src_a_o` = instr[5:3] and `rf_src_b_o` = instr[2:0], for every opcode group.
- R3: `opb_imm_o` equals instr[15]. `wb_mem_o` is 1 only for loads (group 011).
- R4: `rf_we_o` is 1 for groups 000, 001, 011, 100 and 101. `dmem_we_o` is 1 only for stores (group 010).
- R5: For groups 000, 001, 100 and 101, `alu_fn_o` equals instr[13:9]. For all other groups it is the pass-through code 5'b00111.
- R6: For groups 000 to 101, the program counter advances by 1 at the rising clock edge.
- R7: For a jump (group 111), the program counter loads PC + sign-extended {instr[8:6], instr[2:0]}.
- R8: For a branch (group 110), the program counter loads the R7 target when the condition in instr[11:9] holds, and otherwise advances by 1. The condition codes are: 000 never, 001 N, 010 C, 011 Z, 100 V, 101 not Z, 110 not N, 111 always.
- R9: Branches and jumps assert neither `rf_we_o` nor `dmem_we_o`.
- R10: Program-counter arithmetic wraps modulo 2^16.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock, rising edge |
| rst_ni | input | 1 | Asynchronous reset, active low |
| instr_i | input | 16 | Instruction read at `imem_addr_o` |
| flag_v_i | input | 1 | ALU overflow flag |
| flag_c_i | input | 1 | ALU carry flag |
| flag_n_i | input | 1 | ALU negative flag |
| flag_z_i | input | 1 | ALU zero flag |
| imem_addr_o | output | 16 | Program counter / instruction address |
| rf_we_o | output | 1 | Register-file write enable |
| rf_dst_o | output | 3 | Destination register select |
| rf_src_a_o | output | 3 | First source register select |
| rf_src_b_o | output | 3 | Second source register select |
| opb_imm_o | output | 1 | Operand B takes the immediate |
| wb_mem_o | output | 1 | Write-back takes memory data instead of ALU result |
| alu_fn_o | output | 5 | ALU function select |
| dmem_we_o | output | 1 | Data-memory write enable |

## Verification
Each of the eight opcode groups is issued with distinct register fields and function bits. This separates field slicing from group decoding, and shows whether the pass-through override hits only the non-ALU groups.

Every branch condition is tried once with its flag pattern true and once with it false. This pattern tells a swapped or inverted condition code apart from a correct one. Jumps use the extreme offsets +31 and -32, and a backward jump from address 0 exercises wrap-around. A reset in mid-run confirms that the counter returns to 0 from a non-zero value.

// File: rtl/ctl_pkg.sv
package ctl_pkg;
  localparam int INSTR_W = 16;
  localparam int REG_W   = 3;
  localparam int FN_W    = 5;
  localparam int OFF_W   = 6;
  localparam logic [FN_W-1:0] FN_PASS_A = 5'b00111;

  typedef enum logic [2:0] {
    OP_ALU_R  = 3'b000,
    OP_SHF_R  = 3'b001,
    OP_STORE  = 3'b010,
    OP_LOAD   = 3'b011,
    OP_ALU_I  = 3'b100,
    OP_SHF_I  = 3'b101,
    OP_BRANCH = 3'b110,
    OP_JUMP   = 3'b111
  } opgrp_e;

  typedef enum logic [2:0] {
    CND_NEVER  = 3'b000,
    CND_NEG    = 3'b001,
    CND_CARRY  = 3'b010,
    CND_ZERO   = 3'b011,
    CND_OVF    = 3'b100,
    CND_NZERO  = 3'b101,
    CND_NNEG   = 3'b110,
    CND_ALWAYS = 3'b111
  } cond_e;

  typedef struct packed {
    logic             rf_we;
    logic [REG_W-1:0] dst;
    logic [REG_W-1:0] src_a;
    logic [REG_W-1:0] src_b;
    logic             opb_imm;
    logic             wb_mem;
    logic [FN_W-1:0]  alu_fn;
    logic             dmem_we;
  } ctrl_word_t;

  typedef struct packed {
    logic             redirect;  // jump or branch
    logic             uncond;    // jump
    logic [2:0]       cond;
    logic [OFF_W-1:0] off;
  } flow_t;
endpackage

// File: rtl/ctl_decoder.sv
module ctl_decoder
  import ctl_pkg::*;
(
  input  logic [INSTR_W-1:0] instr_i,
  output ctrl_word_t         ctrl_o,
  output flow_t              flow_o
);
  logic [2:0] grp;
  logic       i15, i14, i13;
  logic       alu_grp;

  assign grp = instr_i[15:13];
  assign i15 = instr_i[15];
  assign i14 = instr_i[14];
  assign i13 = instr_i[13];

  always_comb begin
    case (opgrp_e'(grp))
      OP_ALU_R, OP_SHF_R, OP_ALU_I, OP_SHF_I: alu_grp = 1'b1;
      default:                                alu_grp = 1'b0;
    endcase
  end

  always_comb begin
    ctrl_o.dst     = instr_i[8:6];
    ctrl_o.src_a   = instr_i[5:3];
    ctrl_o.src_b   = instr_i[2:0];
    ctrl_o.opb_imm = i15;
    ctrl_o.rf_we   = ~i14 | (~i15 & i13);
    ctrl_o.dmem_we = ~i15 & i14 & ~i13;
    // memory write-back only matters when the register file is written
    ctrl_o.wb_mem  = i14 & ctrl_o.rf_we;
    ctrl_o.alu_fn  = alu_grp ? instr_i[13:9] : FN_PASS_A;
  end

  always_comb begin
    flow_o.redirect = i15 & i14;
    flow_o.uncond   = i13;
    flow_o.cond     = instr_i[11:9];
    flow_o.off      = {instr_i[8:6], instr_i[2:0]};
  end
endmodule

// File: rtl/ctl_branch.sv
module ctl_branch
  import ctl_pkg::*;
#(
  parameter int PC_W = 16
) (
  input  flow_t           flow_i,
  input  logic            flag_v_i,
  input  logic            flag_c_i,
  input  logic            flag_n_i,
  input  logic            flag_z_i,
  input  logic [PC_W-1:0] pc_i,
  output logic [PC_W-1:0] next_pc_o
);
  localparam int EXT_W = PC_W - OFF_W;

  logic            cond_ok;
  logic            take;
  logic [PC_W-1:0] off_ext;
  logic [PC_W-1:0] target;
  logic [PC_W-1:0] seq_pc;

  always_comb begin
    case (cond_e'(flow_i.cond))
      CND_NEVER:  cond_ok = 1'b0;
      CND_NEG:    cond_ok = flag_n_i;
      CND_CARRY:  cond_ok = flag_c_i;
      CND_ZERO:   cond_ok = flag_z_i;
      CND_OVF:    cond_ok = flag_v_i;
      CND_NZERO:  cond_ok = ~flag_z_i;
      CND_NNEG:   cond_ok = ~flag_n_i;
      default:    cond_ok = 1'b1;
    endcase
  end

  assign take    = flow_i.redirect & (flow_i.uncond | cond_ok);
  assign off_ext = {{EXT_W{flow_i.off[OFF_W-1]}}, flow_i.off};
  // one adder shared by jumps and taken branches
  assign target  = pc_i + off_ext;
  assign seq_pc  = pc_i + PC_W'(1);

  assign next_pc_o = take ? target : seq_pc;
endmodule

// File: rtl/ctl_pc.sv
module ctl_pc #(
  parameter int PC_W = 16
) (
  input  logic            clk_i,
  input  logic            rst_ni,
  input  logic [PC_W-1:0] next_pc_i,
  output logic [PC_W-1:0] pc_o
);
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) pc_o <= '0;
    else         pc_o <= next_pc_i;
  end
endmodule

// File: rtl/cpu_ctl.sv
module cpu_ctl
  import ctl_pkg::*;
#(
  parameter int PC_W = 16
) (
  input  logic                 clk_i,
  input  logic                 rst_ni,
  input  logic [INSTR_W-1:0]   instr_i,
  input  logic                 flag_v_i,
  input  logic                 flag_c_i,
  input  logic                 flag_n_i,
  input  logic                 flag_z_i,
  output logic [PC_W-1:0]      imem_addr_o,
  output logic                 rf_we_o,
  output logic [REG_W-1:0]     rf_dst_o,
  output logic [REG_W-1:0]     rf_src_a_o,
  output logic [REG_W-1:0]     rf_src_b_o,
  output logic                 opb_imm_o,
  output logic                 wb_mem_o,
  output logic [FN_W-1:0]      alu_fn_o,
  output logic                 dmem_we_o
);
  ctrl_word_t      ctrl;
  flow_t           flow;
  logic [PC_W-1:0] pc_q;
  logic [PC_W-1:0] pc_d;

  ctl_decoder u_dec (
    .instr_i (instr_i),
    .ctrl_o  (ctrl),
    .flow_o  (flow)
  );

  ctl_branch #(.PC_W(PC_W)) u_br (
    .flow_i    (flow),
    .flag_v_i  (flag_v_i),
    .flag_c_i  (flag_c_i),
    .flag_n_i  (flag_n_i),
    .flag_z_i  (flag_z_i),
    .pc_i      (pc_q),
    .next_pc_o (pc_d)
  );

  ctl_pc #(.PC_W(PC_W)) u_pc (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .next_pc_i (pc_d),
    .pc_o      (pc_q)
  );

  assign imem_addr_o = pc_q;
  assign rf_we_o     = ctrl.rf_we;
  assign rf_dst_o    = ctrl.dst;
  assign rf_src_a_o  = ctrl.src_a;
  assign rf_src_b_o  = ctrl.src_b;
  assign opb_imm_o   = ctrl.opb_imm;
  assign wb_mem_o    = ctrl.wb_mem;
  assign alu_fn_o    = ctrl.alu_fn;
  assign dmem_we_o   = ctrl.dmem_we;
endmodule

// File: rtl/cpu_ctl_chk.sv
module cpu_ctl_chk #(
  parameter int PC_W = 16
) (
  input logic            clk_i,
  input logic            rst_ni,
  input logic [15:0]     instr_i,
  input logic [PC_W-1:0] imem_addr_o,
  input logic            rf_we_o,
  input logic            wb_mem_o,
  input logic [4:0]      alu_fn_o,
  input logic            dmem_we_o
);
  // R1
  a_r1_reset_pc: assert property (@(posedge clk_i)
    !rst_ni |-> imem_addr_o == '0);

  // R6
  a_r6_seq_step: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(instr_i[15] & instr_i[14]) |=> imem_addr_o == $past(imem_addr_o) + PC_W'(1));

  // R7
  a_r7_jump_target: assert property (@(posedge clk_i) disable iff (!rst_ni)
    instr_i[15:13] == 3'b111 |=>
      imem_addr_o == $past(imem_addr_o)
        + {{(PC_W-6){$past(instr_i[8])}}, $past(instr_i[8:6]), $past(instr_i[2:0])});

  // R9
  a_r9_flow_no_write: assert property (@(posedge clk_i) disable iff (!rst_ni)
    instr_i[15:14] == 2'b11 |-> !rf_we_o && !dmem_we_o);

  // R5
  a_r5_branch_pass: assert property (@(posedge clk_i) disable iff (!rst_ni)
    instr_i[15:13] == 3'b110 |-> alu_fn_o == 5'b00111);

  // R4
  a_r4_store_exclusive: assert property (@(posedge clk_i) disable iff (!rst_ni)
    dmem_we_o |-> !rf_we_o && !wb_mem_o);
endmodule

bind cpu_ctl cpu_ctl_chk #(.PC_W(PC_W)) u_chk (
  .clk_i       (clk_i),
  .rst_ni      (rst_ni),
  .instr_i     (instr_i),
  .imem_addr_o (imem_addr_o),
  .rf_we_o     (rf_we_o),
  .wb_mem_o    (wb_mem_o),
  .alu_fn_o    (alu_fn_o),
  .dmem_we_o   (dmem_we_o)
);

// File: tb/cpu_ctl_tb.sv
module cpu_ctl_tb;
  logic        clk_i = 1'b0;
  logic        rst_ni;
  logic [15:0] instr_i = '0;
  logic        flag_v_i = 1'b0, flag_c_i = 1'b0, flag_n_i = 1'b0, flag_z_i = 1'b0;
  logic [15:0] imem_addr_o;
  logic        rf_we_o, opb_imm_o, wb_mem_o, dmem_we_o;
  logic [2:0]  rf_dst_o, rf_src_a_o, rf_src_b_o;
  logic [4:0]  alu_fn_o;

  always #4 clk_i = ~clk_i;

  cpu_ctl u_dut (
    .clk_i(clk_i), .rst_ni(rst_ni), .instr_i(instr_i),
    .flag_v_i(flag_v_i), .flag_c_i(flag_c_i), .flag_n_i(flag_n_i), .flag_z_i(flag_z_i),
    .imem_addr_o(imem_addr_o), .rf_we_o(rf_we_o), .rf_dst_o(rf_dst_o),
    .rf_src_a_o(rf_src_a_o), .rf_src_b_o(rf_src_b_o), .opb_imm_o(opb_imm_o),
    .wb_mem_o(wb_mem_o), .alu_fn_o(alu_fn_o), .dmem_we_o(dmem_we_o)
  );

  typedef struct {
    bit          is_rst;
    logic [15:0] instr;
    logic [15:0] pc;
    string       pc_tag;
    logic        rf_we, opb_imm, wb_mem, dmem_we;
    logic [4:0]  alu_fn;
  } item_t;

  item_t       sb_q[$];
  int          n_chk = 0;
  int          n_fail = 0;
  logic [15:0] m_pc = '0;
  string       m_tag = "R1";
  bit          done = 0;

  task automatic check(string req, string what, logic [15:0] act, logic [15:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s %s: actual %h expected %h", req, what, act, exp);
    end
  endtask

  function automatic bit cond_true(logic [2:0] c, logic v, logic cy, logic n, logic z);
    case (c)
      3'd0: return 1'b0;
      3'd1: return n;
      3'd2: return cy;
      3'd3: return z;
      3'd4: return v;
      3'd5: return !z;
      3'd6: return !n;
      default: return 1'b1;
    endcase
  endfunction

  // driver: called just after a falling edge, returns at the next one
  task automatic issue(logic [15:0] ins, logic [3:0] vcnz, string ptag_ovr = "");
    item_t it;
    logic [2:0]  op;
    logic [15:0] off;
    bit          wrap_tag;
    op = ins[15:13];
    {flag_v_i, flag_c_i, flag_n_i, flag_z_i} = vcnz;
    instr_i = ins;
    it.is_rst  = 0;
    it.instr   = ins;
    it.pc      = m_pc;
    it.pc_tag  = m_tag;
    it.rf_we   = (op == 3'd0 || op == 3'd1 || op == 3'd3 || op == 3'd4 || op == 3'd5);
    it.dmem_we = (op == 3'd2);
    it.opb_imm = ins[15];
    it.wb_mem  = (op == 3'd3);
    it.alu_fn  = (op == 3'd0 || op == 3'd1 || op == 3'd4 || op == 3'd5) ? ins[13:9] : 5'b00111;
    sb_q.push_back(it);
    off = {{10{ins[8]}}, ins[8:6], ins[2:0]};
    if (op == 3'd7) begin
      m_pc = m_pc + off; m_tag = "R7";
    end else if (op == 3'd6) begin
      if (cond_true(ins[11:9], vcnz[3], vcnz[2], vcnz[1], vcnz[0])) m_pc = m_pc + off;
      else m_pc = m_pc + 16'd1;
      m_tag = "R8";
    end else begin
      m_pc = m_pc + 16'd1; m_tag = "R6";
    end
    wrap_tag = (ptag_ovr != "");
    if (wrap_tag) m_tag = ptag_ovr;
    @(negedge clk_i);
  endtask

  task automatic do_reset();
    item_t it;
    rst_ni = 1'b0;
    it.is_rst = 1;
    it.instr  = '0;
    it.pc     = '0;
    it.pc_tag = "R1";
    it.rf_we = 0; it.opb_imm = 0; it.wb_mem = 0; it.dmem_we = 0; it.alu_fn = '0;
    sb_q.push_back(it);
    m_pc = '0;
    m_tag = "R1";
    @(negedge clk_i);
    rst_ni = 1'b1;
  endtask

  function automatic logic [15:0] mk(logic [2:0] op, logic [3:0] mid, logic [2:0] d,
                                     logic [2:0] a, logic [2:0] b);
    return {op, mid, d, a, b};
  endfunction

  // monitor
  initial begin
    forever begin
      @(negedge clk_i);
      #2;
      if (sb_q.size() > 0) begin
        item_t it;
        it = sb_q.pop_front();
        if (it.is_rst) begin
          check("R1", "pc in reset", imem_addr_o, 16'h0000);
        end else begin
          check(it.pc_tag, "pc", imem_addr_o, it.pc);
          check("R2", "dst", 16'(rf_dst_o), 16'(it.instr[8:6]));
          check("R2", "src_a", 16'(rf_src_a_o), 16'(it.instr[5:3]));
          check("R2", "src_b", 16'(rf_src_b_o), 16'(it.instr[2:0]));
          check("R3", "opb_imm", 16'(opb_imm_o), 16'(it.opb_imm));
          check("R3", "wb_mem", 16'(wb_mem_o), 16'(it.wb_mem));
          check(it.instr[15:14] == 2'b11 ? "R9" : "R4", "rf_we", 16'(rf_we_o), 16'(it.rf_we));
          check(it.instr[15:14] == 2'b11 ? "R9" : "R4", "dmem_we", 16'(dmem_we_o), 16'(it.dmem_we));
          check("R5", "alu_fn", 16'(alu_fn_o), 16'(it.alu_fn));
        end
      end
    end
  end

  task automatic finish_run();
    if (!done) begin
      done = 1;
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
    end
  endtask

  // watchdog
  initial begin
    #(8 * 20000);
    n_chk++;
    n_fail++;
    $display("FAIL watchdog: actual timeout expected completion");
    finish_run();
  end

  initial begin
    rst_ni = 1'b0;
    @(negedge clk_i);
    do_reset();                                          // R1
    // one of each group, distinct fields
    issue(mk(3'b000, 4'b1100, 3'd5, 3'd3, 3'd1), 4'h0);  // R2 R5 R6
    issue(mk(3'b001, 4'b0110, 3'd2, 3'd7, 3'd4), 4'h0);
    issue(mk(3'b010, 4'b1010, 3'd0, 3'd6, 3'd5), 4'h0);  // R4 store
    issue(mk(3'b011, 4'b0001, 3'd7, 3'd1, 3'd2), 4'h0);  // R3 load
    issue(mk(3'b100, 4'b0011, 3'd4, 3'd2, 3'd6), 4'h0);
    issue(mk(3'b101, 4'b1111, 3'd1, 3'd4, 3'd3), 4'h0);
    // jumps: +5, +31, -32 (R7)
    issue(mk(3'b111, 4'b0000, 3'b000, 3'd2, 3'b101), 4'h0);
    issue(mk(3'b111, 4'b1010, 3'b011, 3'd5, 3'b111), 4'h0);
    issue(mk(3'b111, 4'b0101, 3'b100, 3'd0, 3'b000), 4'h0);
    // branches: every condition, flags true then false (R8), offset +3
    for (int c = 0; c < 8; c++) begin
      logic [3:0] yes, no;
      case (c)
        1: begin yes = 4'b0010; no = 4'b1101; end
        2: begin yes = 4'b0100; no = 4'b1011; end
        3: begin yes = 4'b0001; no = 4'b1110; end
        4: begin yes = 4'b1000; no = 4'b0111; end
        5: begin yes = 4'b1110; no = 4'b0001; end
        6: begin yes = 4'b1101; no = 4'b0010; end
        default: begin yes = 4'b1111; no = 4'b0000; end
      endcase
      issue(mk(3'b110, {1'b0, 3'(c)}, 3'b000, 3'd3, 3'b011), yes);
      issue(mk(3'b110, {1'b1, 3'(c)}, 3'b111, 3'd4, 3'b110), no);  // offset -2
    end
    issue(mk(3'b000, 4'b0000, 3'd1, 3'd1, 3'd1), 4'h0);
    // mid-run reset from non-zero pc (R1)
    do_reset();
    // wrap: jump -1 from 0 lands on FFFF, then step to 0 (R10)
    issue(mk(3'b111, 4'b0000, 3'b111, 3'd0, 3'b111), 4'h0, "R10");
    issue(mk(3'b100, 4'b0101, 3'd3, 3'd3, 3'd3), 4'h0, "R10");
    issue(mk(3'b000, 4'b0000, 3'd0, 3'd0, 3'd0), 4'h0);
    #3;
    finish_run();
  end
endmodule